// File: doc/BRIEF.md
# No-Touch Leakage Test Sequencer

This block runs a contactless leakage check over a set of serial I/O nodes. It works one node at a time. Each node gets two tests, one for leakage toward ground and one for leakage toward supply. A test has five steps:

1. Drive a known level onto the node.
2. Cut every driver and termination path, so the node floats on its own charge.
3. Wait a programmed decay interval.
4. Capture the node's local comparator, which judges the node against a common-mode reference.
5. Record a failure if the node has drifted to the opposite level.

While a run is in progress, a bypass control shorts the on-die AC coupling capacitor. The result of each test goes into a fail vector and into a sticky overall fail flag. A separate observation pin carries the XOR of every node's comparator. An outside tester can watch that pin and choose its own sampling moment.

The decay interval comes from a programmable counter value. In external-sample mode the counter is ignored. The block then waits in the decay step until the tester pulses a strobe input, and samples in the following cycle.

Top module: `leak_test_seq`

## Requirements
- R1: After reset, busy, done, drive_en, paths_off, ac_bypass, any_fail, obs_pin and every fail_vec bit are 0.
- R2: A run visits tests in this order: node 0 to ground, node 0 to supply, node 1 to ground, and so on up to the last node. A ground test drives drive_lvl=1 and a supply test drives drive_lvl=0.
- R3: Each test first holds drive_en high for exactly DRIVE_CYC cycles. Then drive_en is low and paths_off is high until the sample is taken. The two signals are never high together.
- R4: In counter mode, paths_off stays high for max(wait_cycles,1)+2 cycles per test: one release cycle, the decay wait, and one sample cycle.
- R5: A ground test fails if the comparator reads 0 at the sample, and a supply test fails if it reads 1. A failure sets fail_vec bit 2*node+pol, where pol is 0 for ground and 1 for supply.
- R6: Starting a new run clears fail_vec. any_fail is set by any failure and is cleared only by reset.
- R7: In counter mode, busy is high for exactly 2*N_NODES*(DRIVE_CYC+max(wait_cycles,1)+2) cycles. done then rises and stays high until the next start.
- R8: ac_bypass is high in every cycle in which busy is high, and low otherwise.
- R9: When ext_mode is 1, the decay step lasts until ext_strobe is seen high, whatever wait_cycles holds.
- R10: obs_pin equals the XOR of all cmp_in bits, delayed by one cycle.
- R11: A start pulse while busy is ignored, and the run length and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (idle or done only) |
| wait_cycles | input | WAIT_W | Decay interval in cycles |
| ext_mode | input | 1 | Use the strobe instead of the counter |
| ext_strobe | input | 1 | Tester sample strobe |
| cmp_in | input | N_NODES | Per-node comparator outputs |
| node_sel | output | SEL_W | Node under test |
| drive_en | output | 1 | Drive the selected node |
| drive_lvl | output | 1 | Level to drive |
| paths_off | output | 1 | All drivers and terminations cut |
| ac_bypass | output | 1 | AC coupling capacitor bypass |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail_vec | output | 2*N_NODES | Per-node, per-polarity fail bits |
| any_fail | output | 1 | Sticky overall fail |
| obs_pin | output | 1 | XOR of all comparators, registered |

## Verification
The bench builds the block with N_NODES=4, DRIVE_CYC=3 and WAIT_W=8. With these values a whole run of eight tests fits in a few hundred cycles. A decay of 20 cycles clearly exceeds the modelled leak delays, and a decay of 0 exercises the clamp to one cycle. Four nodes let the bench check both fail-bit positions for two different nodes while the other nodes pass. They also make the ground-to-supply interleave visible in the drive order.

// File: rtl/leak_pkg.sv
package leak_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_RELEASE,
    ST_WAIT,
    ST_SAMPLE,
    ST_DONE
  } leak_st_e;

  typedef enum logic [1:0] {
    T_HOLD,
    T_LD_DRIVE,
    T_LD_WAIT,
    T_DEC
  } tmr_op_e;

  // pol 0 = ground test (drive high), pol 1 = supply test (drive low)
  function automatic logic level_for(input logic pol);
    return ~pol;
  endfunction

  // a node fails when it no longer holds the level it was charged to
  function automatic logic is_leak(input logic pol, input logic seen);
    return seen != level_for(pol);
  endfunction

  function automatic int unsigned tests_per_run(input int unsigned nodes);
    return 2 * nodes;
  endfunction

endpackage

// File: rtl/leak_timer.sv
module leak_timer
  import leak_pkg::*;
#(
  parameter int unsigned WAIT_W    = 16,
  parameter int unsigned DRIVE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_op_e           op,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic              ext_mode,
  input  logic              ext_strobe,
  output logic              cnt_last,
  output logic              wait_done
);
  localparam int unsigned DRV_W = $clog2(DRIVE_CYC + 1);
  localparam int unsigned CNT_W = (WAIT_W > DRV_W) ? WAIT_W : DRV_W;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case (op)
        T_LD_DRIVE: cnt <= CNT_W'(DRIVE_CYC);
        T_LD_WAIT:  cnt <= CNT_W'(wait_cycles);
        T_DEC:      if (cnt != '0) cnt <= cnt - 1'b1;
        default:    ;
      endcase
    end
  end

  // a load of 0 behaves as 1: a step always lasts at least one cycle
  assign cnt_last  = (cnt <= CNT_W'(1));
  assign wait_done = ext_mode ? ext_strobe : cnt_last;

  // R4
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == T_DEC && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/leak_ctrl.sv
module leak_ctrl
  import leak_pkg::*;
#(
  parameter int unsigned N_NODES = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ext_mode,
  input  logic             ext_strobe,
  input  logic             cmp_sel,
  input  logic             cnt_last,
  input  logic             wait_done,
  output tmr_op_e          op,
  output logic [SEL_W-1:0] node,
  output logic             pol,
  output logic             drive_en,
  output logic             paths_off,
  output logic             busy,
  output logic             done,
  output logic             clr,
  output logic             rec_en,
  output logic             rec_fail
);
  leak_st_e         state, state_d;
  logic [SEL_W-1:0] node_d;
  logic             pol_d;
  logic             last_slot;

  assign last_slot = (node == SEL_W'(N_NODES - 1)) && pol;

  always_comb begin
    state_d = state;
    node_d  = node;
    pol_d   = pol;
    op      = T_HOLD;
    clr     = 1'b0;
    rec_en  = 1'b0;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_DRIVE;
          node_d  = '0;
          pol_d   = 1'b0;
          op      = T_LD_DRIVE;
          clr     = 1'b1;
        end
      end
      ST_DRIVE: begin
        if (cnt_last) state_d = ST_RELEASE;
        else          op      = T_DEC;
      end
      ST_RELEASE: begin
        op      = T_LD_WAIT;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (wait_done) state_d = ST_SAMPLE;
        else           op      = T_DEC;
      end
      ST_SAMPLE: begin
        rec_en = 1'b1;
        if (last_slot) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_DRIVE;
          op      = T_LD_DRIVE;
          if (pol) begin
            pol_d  = 1'b0;
            node_d = node + 1'b1;
          end else begin
            pol_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      node  <= '0;
      pol   <= 1'b0;
    end else begin
      state <= state_d;
      node  <= node_d;
      pol   <= pol_d;
    end
  end

  assign rec_fail  = is_leak(pol, cmp_sel);
  assign drive_en  = (state == ST_DRIVE);
  assign paths_off = (state == ST_RELEASE) || (state == ST_WAIT) || (state == ST_SAMPLE);
  assign busy      = (state != ST_IDLE) && (state != ST_DONE);
  assign done      = (state == ST_DONE);

  // R3
  drive_cut_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_en && paths_off));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && state == ST_WAIT && !ext_strobe) |=> (state == ST_WAIT));

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !rec_en) |=> (busy && $stable(node)));

endmodule

// File: rtl/leak_results.sv
module leak_results #(
  parameter int unsigned N_NODES = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 rec_en,
  input  logic [SEL_W:0]       rec_idx,
  input  logic                 rec_fail,
  input  logic [N_NODES-1:0]   cmp_in,
  output logic [2*N_NODES-1:0] fail_vec,
  output logic                 any_fail,
  output logic                 obs_pin
);
  localparam int unsigned SLOTS = 2 * N_NODES;

  logic hit_any;
  assign hit_any = rec_en && rec_fail;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = hit_any && (rec_idx == (SEL_W+1)'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fail_vec[s] <= 1'b0;
      else if (clr) fail_vec[s] <= 1'b0;
      else if (hit) fail_vec[s] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_fail <= 1'b0;
      obs_pin  <= 1'b0;
    end else begin
      obs_pin <= ^cmp_in;
      if (hit_any) any_fail <= 1'b1;
    end
  end

  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_fail |=> any_fail);

  // R5
  rec_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_en && rec_fail) |=> (any_fail && fail_vec[$past(rec_idx)]));

endmodule

// File: rtl/leak_test_seq.sv
module leak_test_seq
  import leak_pkg::*;
#(
  parameter int unsigned N_NODES   = 4,
  parameter int unsigned WAIT_W    = 16,
  parameter int unsigned DRIVE_CYC = 4,
  localparam int unsigned SEL_W    = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int unsigned SLOTS    = tests_per_run(N_NODES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WAIT_W-1:0]  wait_cycles,
  input  logic               ext_mode,
  input  logic               ext_strobe,
  input  logic [N_NODES-1:0] cmp_in,
  output logic [SEL_W-1:0]   node_sel,
  output logic               drive_en,
  output logic               drive_lvl,
  output logic               paths_off,
  output logic               ac_bypass,
  output logic               busy,
  output logic               done,
  output logic [SLOTS-1:0]   fail_vec,
  output logic               any_fail,
  output logic               obs_pin
);
  tmr_op_e op;
  logic    cnt_last, wait_done;
  logic    pol, clr, rec_en, rec_fail, cmp_sel;

  assign cmp_sel = cmp_in[node_sel];

  leak_timer #(.WAIT_W(WAIT_W), .DRIVE_CYC(DRIVE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .op(op), .wait_cycles(wait_cycles),
    .ext_mode(ext_mode), .ext_strobe(ext_strobe),
    .cnt_last(cnt_last), .wait_done(wait_done)
  );

  leak_ctrl #(.N_NODES(N_NODES), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_mode(ext_mode),
    .ext_strobe(ext_strobe), .cmp_sel(cmp_sel), .cnt_last(cnt_last),
    .wait_done(wait_done), .op(op), .node(node_sel), .pol(pol),
    .drive_en(drive_en), .paths_off(paths_off), .busy(busy), .done(done),
    .clr(clr), .rec_en(rec_en), .rec_fail(rec_fail)
  );

  leak_results #(.N_NODES(N_NODES), .SEL_W(SEL_W)) u_res (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rec_en(rec_en),
    .rec_idx({node_sel, pol}), .rec_fail(rec_fail), .cmp_in(cmp_in),
    .fail_vec(fail_vec), .any_fail(any_fail), .obs_pin(obs_pin)
  );

  assign drive_lvl = level_for(pol);
  assign ac_bypass = busy;

  // R8
  bypass_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> ac_bypass);

endmodule

// File: tb/leak_test_seq_test.sv
module leak_test_seq_test;
  localparam int N  = 4;
  localparam int D  = 3;
  localparam int WW = 8;

  logic clk = 0, rst_n = 0, start = 0, ext_mode = 0, ext_strobe = 0;
  logic [WW-1:0] wait_cycles = '0;
  logic [N-1:0] cmp_in;
  logic [1:0] node_sel;
  logic drive_en, drive_lvl, paths_off, ac_bypass, busy, done, any_fail, obs_pin;
  logic [2*N-1:0] fail_vec;

  always #5 clk = ~clk;

  leak_test_seq #(.N_NODES(N), .WAIT_W(WW), .DRIVE_CYC(D)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_cycles(wait_cycles),
    .ext_mode(ext_mode), .ext_strobe(ext_strobe), .cmp_in(cmp_in),
    .node_sel(node_sel), .drive_en(drive_en), .drive_lvl(drive_lvl),
    .paths_off(paths_off), .ac_bypass(ac_bypass), .busy(busy), .done(done),
    .fail_vec(fail_vec), .any_fail(any_fail), .obs_pin(obs_pin)
  );

  int errors = 0, checks = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // analog node model: 0 in a delay means no leak in that direction
  int  gnd_dly [N];
  int  vcc_dly [N];
  int  age     [N];
  logic lvl    [N];
  for (genvar n = 0; n < N; n++) begin : g_cmp
    assign cmp_in[n] = lvl[n];
  end

  int  po_run = 0, last_po = 0, drv_run = 0, last_drv = 0, busy_cnt = 0, byp_err = 0;
  bit  prev_drv = 0, auto_strobe = 0;
  int  ord_node [$];
  int  ord_lvl  [$];

  always @(negedge clk) begin
    for (int n = 0; n < N; n++) begin
      if (drive_en && node_sel == n) begin
        lvl[n] = drive_lvl;
        age[n] = 0;
      end else begin
        age[n]++;
        if (gnd_dly[n] != 0 && age[n] >= gnd_dly[n]) lvl[n] = 1'b0;
        if (vcc_dly[n] != 0 && age[n] >= vcc_dly[n]) lvl[n] = 1'b1;
      end
    end
    if (paths_off) po_run++;
    else begin
      if (po_run > 0) last_po = po_run;
      po_run = 0;
    end
    if (drive_en) drv_run++;
    else begin
      if (drv_run > 0) last_drv = drv_run;
      drv_run = 0;
    end
    if (drive_en && !prev_drv) begin
      ord_node.push_back(int'(node_sel));
      ord_lvl.push_back(int'(drive_lvl));
    end
    prev_drv = drive_en;
    if (start && !busy) busy_cnt = 0;
    else if (busy) busy_cnt++;
    if (ac_bypass != busy) byp_err++;
    ext_strobe = auto_strobe && paths_off && po_run == 30;
  end

  // scoreboard
  typedef struct { int vec; int any; int len; } exp_t;
  exp_t exp_q [$];

  initial begin
    forever begin
      @(posedge done);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(fail_vec) == e.vec, "R5 fail_vec", int'(fail_vec), e.vec);
        check(int'(any_fail) == e.any, "R6 any_fail", int'(any_fail), e.any);
        if (e.len >= 0)
          check(busy_cnt == e.len, "R7/R11 busy length", busy_cnt, e.len);
      end
    end
  end

  function automatic int run_len(input int w);
    return 2 * N * (D + ((w == 0) ? 1 : w) + 2);
  endfunction

  task automatic pulse_start();
    @(posedge clk); #2 start = 1;
    @(posedge clk); #2 start = 0;
  endtask

  task automatic run_test(input int w, input bit ext, input int vec, input int any,
                          input bit poke);
    exp_t e;
    e.vec = vec; e.any = any; e.len = ext ? -1 : run_len(w);
    exp_q.push_back(e);
    wait_cycles = WW'(w);
    ext_mode = ext;
    auto_strobe = ext;
    pulse_start();
    if (poke) begin
      repeat (50) @(posedge clk);
      check(ac_bypass == 1'b1, "R8 bypass mid-run", int'(ac_bypass), 1);
      pulse_start();
    end
    @(negedge clk);
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    report();
  end

  initial begin
    for (int n = 0; n < N; n++) begin
      gnd_dly[n] = 0; vcc_dly[n] = 0; age[n] = 0; lvl[n] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(!busy && !done && !drive_en && !paths_off && !ac_bypass, "R1 control idle",
          {busy, done, drive_en, paths_off, ac_bypass}, 0);
    check(fail_vec == '0 && !any_fail && !obs_pin, "R1 results clear",
          int'({fail_vec, any_fail, obs_pin}), 0);

    // run 1: node1 leaks to ground, node2 leaks to supply, long decay, start poked mid-run
    gnd_dly[1] = 4; vcc_dly[2] = 4;
    run_test(20, 0, 'h24, 1, 1);
    check(ord_node.size() == 2 * N, "R2 test count", ord_node.size(), 2 * N);
    for (int k = 0; k < 2 * N && k < ord_node.size(); k++) begin
      check(ord_node[k] == k / 2, "R2 node order", ord_node[k], k / 2);
      check(ord_lvl[k] == ((k % 2) ? 0 : 1), "R2 drive level", ord_lvl[k], (k % 2) ? 0 : 1);
    end
    ord_node.delete(); ord_lvl.delete();
    check(last_drv == D, "R3 drive length", last_drv, D);
    check(last_po == 22, "R4 released span wait=20", last_po, 22);
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R7 done held", int'(done), 1);
    check(obs_pin == ^cmp_in, "R10 xor pin", int'(obs_pin), int'(^cmp_in));

    // run 2: slow leaks, zero wait clamps to one cycle, any_fail stays set
    gnd_dly[1] = 10; vcc_dly[2] = 10;
    run_test(0, 0, 0, 1, 0);
    check(last_po == 3, "R4 released span wait=0", last_po, 3);

    // run 3: external strobe mode, node3 leaks to ground after 15 cycles
    gnd_dly[1] = 0; vcc_dly[2] = 0; gnd_dly[3] = 15;
    run_test(1, 1, 'h40, 1, 0);
    check(last_po >= 30 && last_po <= 34, "R9 strobe-timed span", last_po, 32);
    check(byp_err == 0, "R8 bypass tracks busy", byp_err, 0);
    check(obs_pin == ^cmp_in, "R10 xor pin after run", int'(obs_pin), int'(^cmp_in));
    check(exp_q.size() == 0, "R7 all runs completed", exp_q.size(), 0);
    report();
  end
endmodule